// File: doc/BRIEF.md
# Interrupt Status Save and Restore Sequencer

This block takes over from the processor core when an interrupt is to be taken at an instruction boundary. When the core reports that it has reached the fetch decision point and an unmasked request is pending, the sequencer acknowledges the request. It writes the current status to a fixed save area and then reads a replacement status from a second fixed area. The core's program counter and three condition flags are reloaded from the bytes it reads, so execution resumes inside the handler. Control then returns to fetch.

The sequence is a fixed chain of ten states. The idle fetch state is followed by five save states (F0, D2, D3, D0, D1) and four restore states (C2, C3, C0, C1). Memory traffic uses a simple byte port. A request stays on the port until the memory raises ready. The core sees a busy level while the chain runs, and then a one-cycle load pulse carrying the new program counter and flags.

Top module: `irq_psw_seq`

## Requirements
- R1: After reset, `busy_o`, `irq_ack_o`, `mem_req_o`, `pc_load_o` and `flag_load_o` are all low.
- R2: In a cycle where `fetch_chk_i` and `irq_req_i` are high and `irq_mask_i` is low, the sequencer enters F0 at the next edge. `irq_ack_o` is high for exactly one cycle, the first cycle of F0.
- R3: No diversion takes place while `irq_mask_i` is high, or while `fetch_chk_i` is low. In these cases `busy_o`, `irq_ack_o` and `mem_req_o` stay low.
- R4: The save phase performs four writes (`mem_we_o`=1) to addresses 0x0300, 0x0301, 0x0302 and 0x0303, in that order. The data is the status byte, 0x00, PC[15:8] and PC[7:0].
- R5: The saved status byte carries `flag_i[0]` in bit 5, `flag_i[1]` in bit 4 and `flag_i[2]` in bit 0. Every other bit is 0.
- R6: Each access holds `mem_req_o`, address, direction and write data until a cycle with `mem_rdy_i` high. The state advances only at that edge, so an access lasts one cycle more than the number of wait cycles.
- R7: After the last write, exactly one busy cycle passes without an access (state D1). The restore phase then performs four reads (`mem_we_o`=0) from 0x0304, 0x0305, 0x0306 and 0x0307, in that order.
- R8: In the cycle after the read of 0x0307 completes, `pc_load_o` and `flag_load_o` are high for one cycle. At that time `pc_o` = {byte at 0x0306, byte at 0x0307}, and `flag_o[0]`, `flag_o[1]` and `flag_o[2]` equal bits 5, 4 and 0 of the byte at 0x0304. The byte at 0x0305 has no effect.
- R9: `busy_o` is high from the first F0 cycle through the last C1 cycle, and low in the load-pulse cycle.
- R10: The PC and flags are captured at entry. Changes on `pc_i` and `flag_i` during the sequence do not alter the saved bytes.
- R11: If the entry condition holds in the load-pulse cycle, the sequencer re-enters F0 at once. The saved PC and flags are then the freshly loaded `pc_o` and `flag_o`, not `pc_i` and `flag_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_chk_i | input | 1 | Core is at the fetch decision point |
| irq_req_i | input | 1 | Interrupt request level |
| irq_mask_i | input | 1 | Interrupt mask |
| irq_ack_o | output | 1 | One-cycle acknowledge that clears the request |
| busy_o | output | 1 | Sequence in progress |
| flag_i | input | 3 | Current condition flags |
| flag_o | output | 3 | Restored condition flags |
| flag_load_o | output | 1 | Load strobe for `flag_o` |
| pc_i | input | 16 | Current program counter |
| pc_o | output | 16 | Handler program counter |
| pc_load_o | output | 1 | Load strobe for `pc_o` |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid with ready |
| mem_rdy_i | input | 1 | Access completes at this edge |

## Verification
The reload of the program counter and a fresh interrupt entry can coincide. This happens in the load-pulse cycle, when a second request is still pending at the fetch point. The bench holds the request and the fetch check high across the whole first sequence, so the second entry decision falls in exactly the cycle that delivers the handler address. It then judges the second save against the first handler's PC and the flags just restored, while `pc_i` still holds an unrelated value. Flags, status bytes and wait lengths are swept, and every written byte, read address and reloaded value is predicted arithmetically.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [3:0] {
        ST_FETCH = 4'h0,
        ST_F0    = 4'h1,
        ST_D2    = 4'h2,
        ST_D3    = 4'h3,
        ST_D0    = 4'h4,
        ST_D1    = 4'h5,
        ST_C2    = 4'h6,
        ST_C3    = 4'h7,
        ST_C0    = 4'h8,
        ST_C1    = 4'h9
    } seq_state_t;

    // one memory access: request, direction and byte slot within the area
    typedef struct packed {
        logic       req;
        logic       we;
        logic [1:0] slot;
    } access_t;

    localparam int NFLAG = 3;
    // bit position of each flag inside the status byte
    localparam int FLAG_POS [NFLAG] = '{5, 4, 0};

    localparam logic [1:0] SLOT_STATUS = 2'd0;
    localparam logic [1:0] SLOT_PAD    = 2'd1;
    localparam logic [1:0] SLOT_PCHI   = 2'd2;
    localparam logic [1:0] SLOT_PCLO   = 2'd3;

    function automatic seq_state_t seq_next(input seq_state_t s);
        case (s)
            ST_F0:   return ST_D2;
            ST_D2:   return ST_D3;
            ST_D3:   return ST_D0;
            ST_D0:   return ST_D1;
            ST_D1:   return ST_C2;
            ST_C2:   return ST_C3;
            ST_C3:   return ST_C0;
            ST_C0:   return ST_C1;
            default: return ST_FETCH;
        endcase
    endfunction

endpackage

// File: rtl/irq_seq_step.sv
module irq_seq_step
    import irq_seq_pkg::*;
(
    input  seq_state_t st_i,
    output access_t    acc_o
);

    always_comb begin
        acc_o = '0;
        case (st_i)
            ST_F0: acc_o = '{req: 1'b1, we: 1'b1, slot: SLOT_STATUS};
            ST_D2: acc_o = '{req: 1'b1, we: 1'b1, slot: SLOT_PAD};
            ST_D3: acc_o = '{req: 1'b1, we: 1'b1, slot: SLOT_PCHI};
            ST_D0: acc_o = '{req: 1'b1, we: 1'b1, slot: SLOT_PCLO};
            ST_C2: acc_o = '{req: 1'b1, we: 1'b0, slot: SLOT_STATUS};
            ST_C3: acc_o = '{req: 1'b1, we: 1'b0, slot: SLOT_PAD};
            ST_C0: acc_o = '{req: 1'b1, we: 1'b0, slot: SLOT_PCHI};
            ST_C1: acc_o = '{req: 1'b1, we: 1'b0, slot: SLOT_PCLO};
            default: acc_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_psw_codec.sv
module irq_psw_codec
    import irq_seq_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [NFLAG-1:0]  flags_i,
    output logic [BYTE_W-1:0] byte_o,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [NFLAG-1:0]  flags_o
);

    always_comb begin
        byte_o = '0;
        for (int i = 0; i < NFLAG; i++) begin
            byte_o[FLAG_POS[i]] = flags_i[i];
        end
    end

    always_comb begin
        for (int i = 0; i < NFLAG; i++) begin
            flags_o[i] = byte_i[FLAG_POS[i]];
        end
    end

endmodule

// File: rtl/irq_psw_seq.sv
module irq_psw_seq
    import irq_seq_pkg::*;
#(
    parameter int          BYTE_W    = 8,
    parameter int          ADDR_W    = 16,
    parameter int unsigned SAVE_BASE = 'h0300,
    parameter int unsigned LOAD_BASE = 'h0304,
    localparam int         PC_W      = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_chk_i,
    input  logic              irq_req_i,
    input  logic              irq_mask_i,
    output logic              irq_ack_o,
    output logic              busy_o,
    input  logic [NFLAG-1:0]  flag_i,
    output logic [NFLAG-1:0]  flag_o,
    output logic              flag_load_o,
    input  logic [PC_W-1:0]   pc_i,
    output logic [PC_W-1:0]   pc_o,
    output logic              pc_load_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    input  logic [BYTE_W-1:0] mem_rdata_i,
    input  logic              mem_rdy_i
);

    localparam logic [ADDR_W-1:0] SAVE_A = ADDR_W'(SAVE_BASE);
    localparam logic [ADDR_W-1:0] LOAD_A = ADDR_W'(LOAD_BASE);

    typedef struct packed {
        seq_state_t       st;
        logic             ack;
        logic             pc_load;
        logic [PC_W-1:0]  pc_snap;
        logic [NFLAG-1:0] fl_snap;
        logic [BYTE_W-1:0] stat_rd;
        logic [BYTE_W-1:0] pchi_rd;
        logic [PC_W-1:0]  pc_out;
        logic [NFLAG-1:0] fl_out;
    } regs_t;

    regs_t q, d;
    access_t acc;
    logic [BYTE_W-1:0] stat_byte;
    logic [NFLAG-1:0]  rd_flags;
    logic              enter;

    irq_seq_step u_step (
        .st_i  (q.st),
        .acc_o (acc)
    );

    irq_psw_codec #(.BYTE_W(BYTE_W)) u_codec (
        .flags_i (q.fl_snap),
        .byte_o  (stat_byte),
        .byte_i  (q.stat_rd),
        .flags_o (rd_flags)
    );

    assign enter = fetch_chk_i && irq_req_i && !irq_mask_i;

    always_comb begin
        d         = q;
        d.ack     = 1'b0;
        d.pc_load = 1'b0;
        unique case (q.st)
            ST_FETCH: begin
                if (enter) begin
                    d.st      = ST_F0;
                    d.ack     = 1'b1;
                    // a reload strobed this cycle has not reached the core yet
                    d.pc_snap = q.pc_load ? q.pc_out : pc_i;
                    d.fl_snap = q.pc_load ? q.fl_out : flag_i;
                end
            end
            ST_D1: d.st = seq_next(q.st);
            default: begin
                if (acc.req && mem_rdy_i) begin
                    d.st = seq_next(q.st);
                    if (!acc.we) begin
                        case (acc.slot)
                            SLOT_STATUS: d.stat_rd = mem_rdata_i;
                            SLOT_PCHI:   d.pchi_rd = mem_rdata_i;
                            SLOT_PCLO: begin
                                d.pc_out  = {q.pchi_rd, mem_rdata_i};
                                d.fl_out  = rd_flags;
                                d.pc_load = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (acc.slot)
            SLOT_STATUS: mem_wdata_o = stat_byte;
            SLOT_PCHI:   mem_wdata_o = q.pc_snap[PC_W-1 -: BYTE_W];
            SLOT_PCLO:   mem_wdata_o = q.pc_snap[BYTE_W-1:0];
            default:     mem_wdata_o = '0;
        endcase
    end

    assign mem_req_o   = acc.req;
    assign mem_we_o    = acc.we;
    assign mem_addr_o  = (acc.we ? SAVE_A : LOAD_A) + ADDR_W'(acc.slot);
    assign irq_ack_o   = q.ack;
    assign busy_o      = (q.st != ST_FETCH);
    assign pc_o        = q.pc_out;
    assign flag_o      = q.fl_out;
    assign pc_load_o   = q.pc_load;
    assign flag_load_o = q.pc_load;

    assert_ack_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> irq_ack_o);
    assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack_o |=> !irq_ack_o);
    assert_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && irq_mask_i) |=> !irq_ack_o);
    assert_save_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> (mem_addr_o >= SAVE_A && mem_addr_o < SAVE_A + ADDR_W'(4)));
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_we_o) && $stable(mem_wdata_o)));
    assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> $past(mem_req_o && !mem_we_o && mem_rdy_i
                            && mem_addr_o == LOAD_A + ADDR_W'(3)));
    assert_busy_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> !busy_o);

endmodule

// File: tb/sim_irq_psw_seq.sv
module sim_irq_psw_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_chk_i, irq_req_i, irq_mask_i;
    logic        irq_ack_o, busy_o;
    logic [2:0]  flag_i, flag_o;
    logic        flag_load_o;
    logic [15:0] pc_i, pc_o;
    logic        pc_load_o;
    logic        mem_req_o, mem_we_o;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_wdata_o, mem_rdata_i;
    logic        mem_rdy_i;

    always #5 clk = ~clk;

    irq_psw_seq u0 (
        .clk(clk), .rst_n(rst_n), .fetch_chk_i(fetch_chk_i), .irq_req_i(irq_req_i),
        .irq_mask_i(irq_mask_i), .irq_ack_o(irq_ack_o), .busy_o(busy_o),
        .flag_i(flag_i), .flag_o(flag_o), .flag_load_o(flag_load_o),
        .pc_i(pc_i), .pc_o(pc_o), .pc_load_o(pc_load_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_rdy_i(mem_rdy_i)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [7:0]  mem [0:7];
    logic [15:0] log_addr [0:15];
    logic [7:0]  log_data [0:15];
    logic        log_we   [0:15];
    int log_n = 0, idle_n = 0, reqc = 0, ack_n = 0;
    int lat = 0, waitc = 0;

    // memory responder, driven away from the active edge
    always @(negedge clk) begin
        if (busy_o && !mem_req_o) idle_n++;
        if (irq_ack_o) ack_n++;
        if (mem_req_o) begin
            reqc++;
            if (waitc >= lat) begin
                mem_rdy_i = 1'b1;
                waitc = 0;
                if (log_n < 16) begin
                    log_addr[log_n] = mem_addr_o;
                    log_we[log_n]   = mem_we_o;
                    log_data[log_n] = mem_we_o ? mem_wdata_o : mem[mem_addr_o[2:0]];
                end
                log_n++;
                if (mem_we_o) mem[mem_addr_o[2:0]] = mem_wdata_o;
                else          mem_rdata_i = mem[mem_addr_o[2:0]];
            end else begin
                mem_rdy_i = 1'b0;
                waitc++;
            end
        end else begin
            mem_rdy_i = 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status(input logic [2:0] f);
        return {2'b00, f[0], f[1], 3'b000, f[2]};
    endfunction

    function automatic logic [2:0] exp_flags(input logic [7:0] s);
        return {s[0], s[4], s[5]};
    endfunction

    task automatic clear_counts();
        log_n = 0; idle_n = 0; reqc = 0; ack_n = 0; waitc = 0;
    endtask

    task automatic wait_load();
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (pc_load_o) break;
        end
        chk("R8 load pulse", 32'(pc_load_o), 32'd1);
    endtask

    task automatic check_save(input logic [15:0] pc, input logic [2:0] fl, input string tag);
        logic [7:0] ed [0:3];
        ed[0] = exp_status(fl); ed[1] = 8'h00; ed[2] = pc[15:8]; ed[3] = pc[7:0];
        for (int i = 0; i < 4; i++) begin
            chk({tag, " R4 write addr"}, 32'(log_addr[i]), 32'h0300 + 32'(i));
            chk({tag, " R4 write dir"}, 32'(log_we[i]), 32'd1);
            chk({tag, " R4/R5 write data"}, 32'(log_data[i]), 32'(ed[i]));
        end
    endtask

    task automatic run_irq(input logic [15:0] pc, input logic [2:0] fl,
                           input logic [7:0] st, input logic [15:0] hpc, input int l);
        lat = l;
        mem[4] = st; mem[5] = ~st; mem[6] = hpc[15:8]; mem[7] = hpc[7:0];
        @(negedge clk);
        clear_counts();
        pc_i = pc; flag_i = fl; fetch_chk_i = 1'b1; irq_req_i = 1'b1; irq_mask_i = 1'b0;
        @(negedge clk);
        chk("R2 entry busy", 32'(busy_o), 32'd1);
        chk("R2 entry ack", 32'(irq_ack_o), 32'd1);
        fetch_chk_i = 1'b0; irq_req_i = 1'b0;
        pc_i = ~pc; flag_i = ~fl;               // R10: late changes must not leak
        wait_load();
        chk("R9 busy low at load", 32'(busy_o), 32'd0);
        chk("R8 flag strobe", 32'(flag_load_o), 32'd1);
        chk("R8 pc value", 32'(pc_o), 32'(hpc));
        chk("R8 flag value", 32'(flag_o), 32'(exp_flags(st)));
        chk("R2 ack count", 32'(ack_n), 32'd1);
        chk("R4 access count", 32'(log_n), 32'd8);
        check_save(pc, fl, "R10");
        for (int i = 4; i < 8; i++) begin
            chk("R7 read addr", 32'(log_addr[i]), 32'h0300 + 32'(i));
            chk("R7 read dir", 32'(log_we[i]), 32'd0);
        end
        chk("R7 single gap", 32'(idle_n), 32'd1);
        chk("R6 request cycles", 32'(reqc), 32'(8 * (l + 1)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; fetch_chk_i = 0; irq_req_i = 0; irq_mask_i = 0;
        flag_i = 0; pc_i = 0; mem_rdata_i = 0; mem_rdy_i = 0;
        for (int i = 0; i < 8; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy_o), 0);
        chk("R1 ack", 32'(irq_ack_o), 0);
        chk("R1 mem_req", 32'(mem_req_o), 0);
        chk("R1 pc_load", 32'(pc_load_o), 0);
        chk("R1 flag_load", 32'(flag_load_o), 0);

        // R3: masked request, and request without fetch check
        for (int m = 0; m < 2; m++) begin
            int seen = 0;
            clear_counts();
            irq_req_i = 1'b1;
            irq_mask_i = (m == 0);
            fetch_chk_i = (m == 0);
            for (int c = 0; c < 12; c++) begin
                @(negedge clk);
                if (busy_o || irq_ack_o || mem_req_o) seen++;
            end
            chk("R3 no diversion", 32'(seen), 0);
            irq_req_i = 0; irq_mask_i = 0; fetch_chk_i = 0;
        end

        // sweep: every flag pattern, three wait lengths, varied status and PC
        for (int l = 0; l < 3; l++) begin
            for (int f = 0; f < 8; f++) begin
                logic [7:0]  st;
                logic [15:0] pc, hpc;
                st  = 8'((f * 37 + l * 91) ^ (f << 4));
                pc  = 16'(16'h1357 * (f + 1) + 16'(l) * 16'h0F0F);
                hpc = 16'(16'hA5C3 ^ (16'(f) << 9) ^ 16'(l * 777));
                run_irq(pc, 3'(f), st, hpc, l);
            end
        end

        // R11: new entry decided in the reload cycle
        lat = 1;
        mem[4] = 8'h21; mem[5] = 8'hFF; mem[6] = 8'hBE; mem[7] = 8'hEF;
        @(negedge clk);
        clear_counts();
        pc_i = 16'h1234; flag_i = 3'b010; fetch_chk_i = 1'b1; irq_req_i = 1'b1; irq_mask_i = 0;
        wait_load();
        chk("R11 first pc", 32'(pc_o), 32'hBEEF);
        clear_counts();
        @(negedge clk);
        chk("R11 re-entry ack", 32'(irq_ack_o), 1);
        chk("R11 re-entry busy", 32'(busy_o), 1);
        fetch_chk_i = 0; irq_req_i = 0;
        wait_load();
        check_save(16'hBEEF, exp_flags(8'h21), "R11");

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule